// File: doc/BRIEF.md
# Flash Attribute and Sleep Controller

This block decides, frame by frame, whether the cursor and each of four screen layers are shown. It also steps the panel drivers through an orderly power-down and back. A frame-tick pulse advances a free-running 6-bit frame counter. Each 2-bit attribute code chooses off, steady on or one of two blink rates, and each code is decoded against that counter. The cursor and the layers read the same code values differently:

- Cursor codes give a slow and a very slow blink, and the cursor is lit for roughly seventy percent of each period.
- Layer codes give a slow and a fast square-wave blink.

A master enable and an internal display-on flag override every attribute.

Sleep is requested by a one-cycle command. The driver enable output stays high until the second frame boundary after the command. It falls there, one blank frame follows, and the block then halts. While halted, the frame counter is frozen and its value is kept. A wake command brings the drivers back at once. The picture stays dark until a display-on command arrives. A memory-write indication forces a blinking cursor on, so that its position stays visible during a burst of writes. A dual-panel input lets the second attribute field drive the fourth layer as well.

Top module: `flash_sleep_ctrl`

## Requirements
- R1: After reset, layerVis and cursorVis are 0, driverEn is 1 and halted is 0.
- R2: Layer fields map as follows: field A drives layer 0, field B drives layer 1 and field C drives layer 2. In each field, code 00 is off and 01 is on. Code 10 is visible while bit 4 of the frame count is 0, and code 11 is visible while bit 1 of the frame count is 0.
- R3: Cursor code 00 is off and 01 is on. Code 10 is visible while (frame count mod 32) < 22, and code 11 is visible while the frame count is < 45.
- R4: The 6-bit frame count starts at 0, advances by one on every frameTick while the block is not halted, and wraps from 63 to 0.
- R5: When dispEnable is 0, or when no display-on command has been seen since reset or the last wake, all layerVis bits and cursorVis are 0.
- R6: While memWriteActive is 1, a cursor with code 10 or 11 is visible at every frame phase. Code 00 stays off.
- R7: With dualPanel at 1, layer 3 follows field B. With dualPanel at 0, layer 3 is 0.
- R8: After sleepCmd, driverEn stays 1 through the first frameTick that follows and goes 0 on the second. A frameTick in the same cycle as sleepCmd is not counted. From then on, all visible outputs are 0.
- R9: halted goes to 1 on the third frameTick after sleepCmd, one blank frame after driverEn falls. While halted is 1, the frame count does not change.
- R10: wakeCmd returns the block from any sleep step. On the next cycle driverEn is 1 and halted is 0, and the display-on flag is cleared. dispOnCmd sets that flag again. The frame count resumes from its retained value. wakeCmd overrides a sleepCmd given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle pulse per frame boundary |
| dispEnable | input | 1 | Master display enable |
| dualPanel | input | 1 | Dual-panel mode; field B also drives layer 3 |
| cursorAttr | input | 2 | Cursor attribute code |
| layerAttrA | input | 2 | Attribute code for layer 0 |
| layerAttrB | input | 2 | Attribute code for layer 1 (and layer 3 in dual mode) |
| layerAttrC | input | 2 | Attribute code for layer 2 |
| memWriteActive | input | 1 | Memory-write burst in progress; forces a blinking cursor on |
| sleepCmd | input | 1 | One-cycle sleep request |
| wakeCmd | input | 1 | One-cycle wake request; also clears the display-on flag |
| dispOnCmd | input | 1 | One-cycle display-on command |
| layerVis | output | 4 | Per-layer visible enables |
| cursorVis | output | 1 | Cursor visible enable |
| driverEn | output | 1 | Driver enable; low while the drivers are blanked |
| halted | output | 1 | Internal operation halted; frame counter frozen |

## Verification
The frame boundary and the sleep command can land in the same cycle. If the sleep sequencer counted that tick, the drivers would drop one frame early. The bench drives sleepCmd and frameTick together on one edge. It then expects driverEn still high after the next tick and low only after the tick after that. It also checks that the coincident tick still advanced the frame counter. To do so it reads the long cursor window, which switches from visible at count 44 to dark at count 45, after wake. A second coincidence, wake and sleep in one cycle, must leave the drivers on across later frames.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    SLP_AWAKE = 3'd0,
    SLP_ARM   = 3'd1,
    SLP_SYNC  = 3'd2,
    SLP_BLANK = 3'd3,
    SLP_HALT  = 3'd4
  } sleepState_t;

  typedef struct packed {
    logic [CNT_W-1:0] frameCnt;
    logic             showEnable;
    logic             forceCursor;
  } ctlStrobes_t;

  // Shared decode for a layer code: off, on, slow blink, fast blink.
  function automatic logic layerCodeVisible(input logic [1:0] code,
                                            input logic slowPhase,
                                            input logic fastPhase);
    logic vis;
    case (code)
      2'b00:   vis = 1'b0;
      2'b01:   vis = 1'b1;
      2'b10:   vis = ~slowPhase;
      default: vis = ~fastPhase;
    endcase
    return vis;
  endfunction

endpackage

// File: rtl/fsc_sleep_ctrl.sv
module fsc_sleep_ctrl
  import fsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameTick,
  input  logic        dispEnable,
  input  logic        memWriteActive,
  input  logic        sleepCmd,
  input  logic        wakeCmd,
  input  logic        dispOnCmd,
  output ctlStrobes_t strobes,
  output logic        driverEn,
  output logic        halted
);

  sleepState_t      state;
  logic [CNT_W-1:0] frameCnt;
  logic             dispOn;
  logic             pictureAlive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SLP_AWAKE;
      driverEn <= 1'b1;
      dispOn   <= 1'b0;
      frameCnt <= '0;
    end else begin
      if (frameTick && state != SLP_HALT)
        frameCnt <= frameCnt + 1'b1;
      if (wakeCmd) begin
        state    <= SLP_AWAKE;
        driverEn <= 1'b1;
        dispOn   <= 1'b0;
      end else begin
        if (dispOnCmd)
          dispOn <= 1'b1;
        case (state)
          SLP_AWAKE: if (sleepCmd)  state <= SLP_ARM;
          SLP_ARM:   if (frameTick) state <= SLP_SYNC;
          SLP_SYNC:  if (frameTick) begin
                       state    <= SLP_BLANK;
                       driverEn <= 1'b0;
                     end
          SLP_BLANK: if (frameTick) state <= SLP_HALT;
          default:   ;
        endcase
      end
    end
  end

  assign pictureAlive = (state == SLP_AWAKE) || (state == SLP_ARM) || (state == SLP_SYNC);
  assign halted       = (state == SLP_HALT);

  assign strobes.frameCnt    = frameCnt;
  assign strobes.showEnable  = dispEnable && dispOn && pictureAlive;
  assign strobes.forceCursor = memWriteActive;

  // R1
  awake_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SLP_AWAKE) |-> driverEn);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && !halted) |=> (frameCnt == $past(frameCnt) + 1'b1));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !wakeCmd) |=> $stable(frameCnt));

  // R8
  driver_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driverEn) |-> $past(frameTick));

  // R10
  wake_restores_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeCmd |=> (driverEn && !halted));

endmodule

// File: rtl/fsc_attr_datapath.sv
module fsc_attr_datapath
  import fsc_pkg::*;
#(
  parameter int NUM_FIELDS    = 3,
  parameter int SLOW_BIT      = 4,
  parameter int FAST_BIT      = 1,
  parameter int CUR_SHORT_MOD = 32,
  parameter int CUR_SHORT_WIN = 22,
  parameter int CUR_LONG_WIN  = 45
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             strobes,
  input  logic                    dualPanel,
  input  logic [1:0]              cursorAttr,
  input  logic [2*NUM_FIELDS-1:0] layerAttr,
  output logic [NUM_FIELDS:0]     layerVis,
  output logic                    cursorVis
);

  localparam int SHORT_W = $clog2(CUR_SHORT_MOD);

  logic [NUM_FIELDS-1:0] fieldOn;
  logic                  mirrorLayer;
  logic                  shortWindow;
  logic                  longWindow;
  logic                  cursorRaw;

  genvar gi;
  for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    assign fieldOn[gi] = layerCodeVisible(layerAttr[2*gi +: 2],
                                          strobes.frameCnt[SLOW_BIT],
                                          strobes.frameCnt[FAST_BIT]);
  end

  assign mirrorLayer = dualPanel && fieldOn[1];
  assign layerVis    = strobes.showEnable ? {mirrorLayer, fieldOn} : '0;

  assign shortWindow = strobes.frameCnt[SHORT_W-1:0] < SHORT_W'(CUR_SHORT_WIN);
  assign longWindow  = strobes.frameCnt < CNT_W'(CUR_LONG_WIN);

  always_comb begin
    case (cursorAttr)
      2'b00:   cursorRaw = 1'b0;
      2'b01:   cursorRaw = 1'b1;
      2'b10:   cursorRaw = shortWindow || strobes.forceCursor;
      default: cursorRaw = longWindow || strobes.forceCursor;
    endcase
  end

  assign cursorVis = strobes.showEnable && cursorRaw;

  // R5
  blank_when_hidden_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.showEnable |-> (layerVis == '0 && !cursorVis));

  // R7
  mirror_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dualPanel |-> !layerVis[NUM_FIELDS]);

  // R6
  forced_cursor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.showEnable && strobes.forceCursor && cursorAttr != 2'b00) |-> cursorVis);

endmodule

// File: rtl/flash_sleep_ctrl.sv
module flash_sleep_ctrl
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       dispEnable,
  input  logic       dualPanel,
  input  logic [1:0] cursorAttr,
  input  logic [1:0] layerAttrA,
  input  logic [1:0] layerAttrB,
  input  logic [1:0] layerAttrC,
  input  logic       memWriteActive,
  input  logic       sleepCmd,
  input  logic       wakeCmd,
  input  logic       dispOnCmd,
  output logic [3:0] layerVis,
  output logic       cursorVis,
  output logic       driverEn,
  output logic       halted
);

  ctlStrobes_t strobes;

  fsc_sleep_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .frameTick      (frameTick),
    .dispEnable     (dispEnable),
    .memWriteActive (memWriteActive),
    .sleepCmd       (sleepCmd),
    .wakeCmd        (wakeCmd),
    .dispOnCmd      (dispOnCmd),
    .strobes        (strobes),
    .driverEn       (driverEn),
    .halted         (halted)
  );

  fsc_attr_datapath #(.NUM_FIELDS(3)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dualPanel  (dualPanel),
    .cursorAttr (cursorAttr),
    .layerAttr  ({layerAttrC, layerAttrB, layerAttrA}),
    .layerVis   (layerVis),
    .cursorVis  (cursorVis)
  );

endmodule

// File: tb/tb_flash_sleep_ctrl.sv
module tb_flash_sleep_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameTick = 1'b0;
  logic       dispEnable = 1'b0;
  logic       dualPanel = 1'b0;
  logic [1:0] cursorAttr = 2'b00;
  logic [1:0] layerAttrA = 2'b00;
  logic [1:0] layerAttrB = 2'b00;
  logic [1:0] layerAttrC = 2'b00;
  logic       memWriteActive = 1'b0;
  logic       sleepCmd = 1'b0;
  logic       wakeCmd = 1'b0;
  logic       dispOnCmd = 1'b0;
  logic [3:0] layerVis;
  logic       cursorVis;
  logic       driverEn;
  logic       halted;

  int checks = 0;
  int errors = 0;
  int cnt = 0;

  always #10 clk = ~clk;

  flash_sleep_ctrl dut (.*);

  // {count, dual, cursor, A, B, C, memWrite, expLayers, expCursor}
  localparam logic [20:0] VEC [0:9] = '{
    {6'd0,  1'b0, 2'd1, 2'd1, 2'd0, 2'd2, 1'b0, 4'b0101, 1'b1},
    {6'd16, 1'b0, 2'd2, 2'd2, 2'd1, 2'd3, 1'b0, 4'b0110, 1'b1},
    {6'd22, 1'b1, 2'd2, 2'd3, 2'd2, 2'd0, 1'b0, 4'b0000, 1'b0},
    {6'd21, 1'b1, 2'd2, 2'd0, 2'd3, 2'd1, 1'b0, 4'b1110, 1'b1},
    {6'd44, 1'b0, 2'd3, 2'd1, 2'd1, 2'd1, 1'b0, 4'b0111, 1'b1},
    {6'd45, 1'b1, 2'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'b1111, 1'b0},
    {6'd45, 1'b1, 2'd3, 2'd3, 2'd3, 2'd3, 1'b1, 4'b1111, 1'b1},
    {6'd54, 1'b0, 2'd2, 2'd2, 2'd2, 2'd0, 1'b0, 4'b0000, 1'b0},
    {6'd54, 1'b0, 2'd0, 2'd1, 2'd0, 2'd0, 1'b1, 4'b0001, 1'b0},
    {6'd63, 1'b1, 2'd2, 2'd3, 2'd1, 2'd2, 1'b0, 4'b1010, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) frameTick = 1'b1;
    @(negedge clk) frameTick = 1'b0;
  endtask

  task automatic advanceTo(input int target);
    int n;
    n = (target - cnt) & 63;
    for (int i = 0; i < n; i++) tick();
    cnt = target;
  endtask

  task automatic pulseWake();
    @(negedge clk) wakeCmd = 1'b1;
    @(negedge clk) wakeCmd = 1'b0;
  endtask

  task automatic pulseDispOn();
    @(negedge clk) dispOnCmd = 1'b1;
    @(negedge clk) dispOnCmd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 layers", layerVis, 4'h0);
    check("R1 cursor", cursorVis, 1'b0);
    check("R1 driverEn", driverEn, 1'b1);
    check("R1 halted", halted, 1'b0);

    // R5: attributes on, enable high, but no display-on yet
    dispEnable = 1'b1;
    cursorAttr = 2'd1; layerAttrA = 2'd1; layerAttrB = 2'd1; layerAttrC = 2'd1;
    @(negedge clk);
    check("R5 no display-on layers", layerVis, 4'h0);
    pulseDispOn();

    // R2 R3 R6 R7 table walk
    foreach (VEC[i]) begin
      advanceTo(int'(VEC[i][20:15]));
      dualPanel      = VEC[i][14];
      cursorAttr     = VEC[i][13:12];
      layerAttrA     = VEC[i][11:10];
      layerAttrB     = VEC[i][9:8];
      layerAttrC     = VEC[i][7:6];
      memWriteActive = VEC[i][5];
      @(negedge clk);
      check("R2/R7 layers", layerVis, VEC[i][4:1]);
      check("R3/R6 cursor", cursorVis, VEC[i][0]);
    end
    memWriteActive = 1'b0;

    // R4: wrap 63 -> 0, fast layer at count 0 visible
    layerAttrA = 2'd3; layerAttrB = 2'd0; layerAttrC = 2'd0; dualPanel = 1'b0;
    cursorAttr = 2'd1;
    tick(); cnt = 0;
    check("R4 wrap to 0", layerVis, 4'b0001);

    // R5: master enable low blanks everything
    dispEnable = 1'b0;
    @(negedge clk);
    check("R5 master off layers", layerVis, 4'h0);
    check("R5 master off cursor", cursorVis, 1'b0);
    dispEnable = 1'b1;

    // Sleep sequence, command coincident with a frame tick
    layerAttrA = 2'd1; cursorAttr = 2'd3;
    advanceTo(40);
    @(negedge clk) begin sleepCmd = 1'b1; frameTick = 1'b1; end
    @(negedge clk) begin sleepCmd = 1'b0; frameTick = 1'b0; end
    cnt = 41;
    check("R8 coincident tick not counted", driverEn, 1'b1);
    tick(); cnt = 42;
    check("R8 high after first tick", driverEn, 1'b1);
    check("R8 still showing", layerVis, 4'b0001);
    tick(); cnt = 43;
    check("R8 low after second tick", driverEn, 1'b0);
    check("R8 blank layers", layerVis, 4'h0);
    check("R9 not yet halted", halted, 1'b0);
    tick(); cnt = 44;
    check("R9 halted after blank frame", halted, 1'b1);
    for (int i = 0; i < 5; i++) tick();
    check("R9 still halted", halted, 1'b1);

    pulseWake();
    check("R10 driverEn back", driverEn, 1'b1);
    check("R10 halted cleared", halted, 1'b0);
    check("R10 display stays off", layerVis, 4'h0);
    pulseDispOn();
    check("R10 display back", layerVis, 4'b0001);
    check("R10 count retained at 44", cursorVis, 1'b1);
    tick(); cnt = 45;
    check("R10 count resumes to 45", cursorVis, 1'b0);

    // R10: wake wins over sleep in the same cycle
    @(negedge clk) begin wakeCmd = 1'b1; sleepCmd = 1'b1; end
    @(negedge clk) begin wakeCmd = 1'b0; sleepCmd = 1'b0; end
    tick(); tick(); tick();
    check("R10 wake beats sleep", driverEn, 1'b1);
    check("R10 wake beats sleep halted", halted, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule